// File: doc/BRIEF.md
# Horizontal Same-Colour Defect Pixel Corrector

This block cleans isolated hot and dead pixels out of a raw Bayer pixel stream, one line at a time. Every pixel is compared with the two pixels of the same colour channel on the same line, which sit two columns to its left and two columns to its right. A pixel is treated as defective if it lies above both of those neighbours by more than a programmable threshold, or below both by more than that threshold. A defective pixel is replaced by the truncated mean of the two neighbours. All other pixels pass through unchanged.

The stream enters as a 10-bit pixel bus qualified by a line-valid strobe. Line-valid is high for one pixel per clock across a line and low between lines. The corrected stream leaves with its own line-valid and a fixed latency. A single enable input switches the correction on or off. The 7-bit threshold is a static input, and the recommended setting after reset is 20. At the end of each line the block drains the pixels it is still holding while line-valid is low, so every line leaves complete.

Top module: `bpr_hline`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, line_valid_o is 0 and pix_o is 0.
- R2: Within a line of three or more pixels, the corrected value of pixel k is presented with line_valid_o high three clock cycles after pixel k was sampled. No output appears until the third pixel of a line has been sampled.
- R3: An interior pixel c with left neighbour L at column k-2 and right neighbour R at column k+2 is bright-defective when c > L + thresh_i and c > R + thresh_i (strict). Equality with the threshold does not count.
- R4: An interior pixel is dark-defective when c + thresh_i < L and c + thresh_i < R (strict).
- R5: With en_i = 1, a pixel that is bright- or dark-defective is output as (L + R) >> 1, truncated. Every other pixel is output unchanged.
- R6: With en_i = 0, every pixel is output unchanged.
- R7: The first two and the last two pixels of a line are never altered, so a line of four or fewer pixels passes through unchanged.
- R8: Every line of N pixels produces exactly N outputs, in input order. After line_valid_i falls, the remaining min(N,2) pixels are output on consecutive cycles, and then line_valid_o stays low. Lines must be separated by at least two idle cycles.
- R9: Only the same-colour neighbours two columns away take part in the decision. The adjacent pixels at columns k-1 and k+1 have no effect on the output for pixel k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Correction enable |
| thresh_i | input | 7 | Defect threshold; recommended reset value 20 |
| line_valid_i | input | 1 | Input pixel valid; high across a line |
| pix_i | input | 10 | Input raw pixel |
| line_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 10 | Corrected pixel |

## Verification
The difficult cases sit right at the threshold. A centre value that exceeds one neighbour by exactly the threshold, while the other neighbour is far away, must not be flagged. Getting that right depends on both neighbours and the threshold lining up at once. The stimulus therefore sweeps short five-pixel lines. It combines several left and right neighbour levels and several thresholds, including 0 and the maximum. For each combination it places the centre one step inside and one step outside the bright band and the dark band. Meanwhile the adjacent odd columns carry the mirrored extreme, which shows they are ignored. Lines of one to four pixels and a long pseudo-random line with injected spikes cover the draining behaviour and the edge behaviour.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int unsigned PIX_W = 10;
  localparam int unsigned THR_W = 7;
  // taps held behind the input: centre at TAPS/2-1, far neighbour at TAPS-1
  localparam int unsigned TAPS  = 4;
endpackage

// File: rtl/bpr_window.sv
module bpr_window
  import bpr_pkg::*;
#(
  parameter int unsigned PW = PIX_W,
  parameter int unsigned NT = TAPS,
  localparam int unsigned HALF   = NT / 2,
  localparam int unsigned CNT_W  = $clog2(NT + 1),
  localparam int unsigned PEND_W = $clog2(HALF + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [PW-1:0]            pix_i,
  output logic [NT-1:0][PW-1:0]    taps_o,
  output logic [CNT_W-1:0]         cnt_o,
  output logic [PEND_W-1:0]        pend_o
);
  logic [NT-1:0][PW-1:0] tap_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [PEND_W-1:0]     pend_q;

  for (genvar g = 0; g < NT; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tap_q[g] <= '0;
      else if (valid_i) tap_q[g] <= (g == 0) ? pix_i : tap_q[(g == 0) ? 0 : g-1];
    end
  end

  // cnt: pixels seen this line (saturating); pend: pixels still owed at line end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (valid_i) begin
      if (cnt_q != CNT_W'(NT)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q >= CNT_W'(HALF - 1)) pend_q <= PEND_W'(HALF);
      else                           pend_q <= PEND_W'(cnt_q) + 1'b1;
    end else begin
      cnt_q <= '0;
      if (pend_q != '0) pend_q <= pend_q - 1'b1;
    end
  end

  assign taps_o = tap_q;
  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/bpr_detect.sv
module bpr_detect
  import bpr_pkg::*;
#(
  parameter int unsigned PW = PIX_W,
  parameter int unsigned TW = THR_W
) (
  input  logic          en_i,
  input  logic          inner_i,
  input  logic [TW-1:0] thr_i,
  input  logic [PW-1:0] left_i,
  input  logic [PW-1:0] center_i,
  input  logic [PW-1:0] right_i,
  output logic          flag_o,
  output logic [PW-1:0] pix_o
);
  localparam int unsigned EW = PW + 1;
  logic [EW-1:0] c_x, l_x, r_x, t_x, sum_x;
  logic          hot, cold;

  always_comb begin
    c_x   = EW'(center_i);
    l_x   = EW'(left_i);
    r_x   = EW'(right_i);
    t_x   = EW'(thr_i);
    hot   = (c_x > l_x + t_x) && (c_x > r_x + t_x);
    cold  = (c_x + t_x < l_x) && (c_x + t_x < r_x);
    sum_x = l_x + r_x;
    flag_o = en_i && inner_i && (hot || cold);
    pix_o  = flag_o ? sum_x[EW-1:1] : center_i;
  end
endmodule

// File: rtl/bpr_hline.sv
module bpr_hline
  import bpr_pkg::*;
#(
  parameter int unsigned PW = PIX_W,
  parameter int unsigned TW = THR_W,
  localparam int unsigned NT     = TAPS,
  localparam int unsigned HALF   = NT / 2,
  localparam int unsigned CNT_W  = $clog2(NT + 1),
  localparam int unsigned PEND_W = $clog2(HALF + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          line_valid_i,
  input  logic [PW-1:0] pix_i,
  output logic          line_valid_o,
  output logic [PW-1:0] pix_o
);
  logic [NT-1:0][PW-1:0] taps_w;
  logic [CNT_W-1:0]      cnt_w;
  logic [PEND_W-1:0]     pend_w;
  logic [PW-1:0]         center_w, left_w, fixed_w, drain_w;
  logic                  flag_w, emit_w, inner_w;

  bpr_window #(.PW(PW), .NT(NT)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(line_valid_i),
    .pix_i  (pix_i),
    .taps_o (taps_w),
    .cnt_o  (cnt_w),
    .pend_o (pend_w)
  );

  assign center_w = taps_w[HALF-1];
  assign left_w   = taps_w[NT-1];
  assign inner_w  = (cnt_w == CNT_W'(NT));
  // at line end the older owed pixel sits at the centre tap, the last at tap 0
  assign drain_w  = (pend_w == PEND_W'(HALF)) ? taps_w[HALF-1] : taps_w[0];
  assign emit_w   = line_valid_i ? (cnt_w >= CNT_W'(HALF)) : (pend_w != '0);

  bpr_detect #(.PW(PW), .TW(TW)) u_det (
    .en_i    (en_i),
    .inner_i (inner_w),
    .thr_i   (thresh_i),
    .left_i  (left_w),
    .center_i(center_w),
    .right_i (pix_i),
    .flag_o  (flag_w),
    .pix_o   (fixed_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_valid_o <= 1'b0;
      pix_o        <= '0;
    end else begin
      line_valid_o <= emit_w;
      if (emit_w) pix_o <= line_valid_i ? fixed_w : drain_w;
    end
  end
endmodule

// File: rtl/bpr_hline_chk.sv
module bpr_hline_chk #(
  parameter int unsigned PW     = 10,
  parameter int unsigned TW     = 7,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned PEND_W = 2,
  parameter int unsigned NT     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [TW-1:0]     thresh_i,
  input logic              line_valid_i,
  input logic [PW-1:0]     pix_i,
  input logic              line_valid_o,
  input logic [PW-1:0]     pix_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [PEND_W-1:0] pend_i,
  input logic [PW-1:0]     center_i,
  input logic [PW-1:0]     left_i
);
  localparam int unsigned HALF = NT / 2;
  logic [PW:0]   sum_c;
  logic [PW-1:0] lo_c, hi_c;
  assign sum_c = {1'b0, left_i} + {1'b0, pix_i};
  assign lo_c  = (left_i < pix_i) ? left_i : pix_i;
  assign hi_c  = (left_i < pix_i) ? pix_i : left_i;

  AST_NO_EARLY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i && cnt_i < CNT_W'(HALF) |=> !line_valid_o); // R2
  AST_EDGE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i && cnt_i >= CNT_W'(HALF) && cnt_i < CNT_W'(NT)
    |=> line_valid_o && pix_o == $past(center_i)); // R7
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i && cnt_i >= CNT_W'(HALF) && !en_i |=> pix_o == $past(center_i)); // R6
  AST_IN_BAND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i && cnt_i == CNT_W'(NT) && center_i >= lo_c && center_i <= hi_c
    |=> pix_o == $past(center_i)); // R3
  AST_FIX_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i && cnt_i == CNT_W'(NT)
    |=> pix_o == $past(center_i) || pix_o == $past(sum_c[PW:1])); // R5
  AST_DRAIN_EMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_valid_i && pend_i != '0 |=> line_valid_o); // R8
  AST_DRAIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_valid_i && pend_i == '0 |=> !line_valid_o); // R8
  AST_THR_STABLE_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i && cnt_i == CNT_W'(NT) && en_i
    && ({1'b0, center_i} > {1'b0, hi_c} + {{(PW+1-TW){1'b0}}, thresh_i})
    |=> pix_o == $past(sum_c[PW:1])); // R3
endmodule

bind bpr_hline bpr_hline_chk #(
  .PW(PW), .TW(TW), .CNT_W(CNT_W), .PEND_W(PEND_W), .NT(NT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .thresh_i    (thresh_i),
  .line_valid_i(line_valid_i),
  .pix_i       (pix_i),
  .line_valid_o(line_valid_o),
  .pix_o       (pix_o),
  .cnt_i       (cnt_w),
  .pend_i      (pend_w),
  .center_i    (center_w),
  .left_i      (left_w)
);

// File: tb/tb_bpr_hline.sv
module tb_bpr_hline;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [6:0] thr = 7'd20;
  logic       lv_i = 1'b0;
  logic [9:0] px_i = '0;
  logic       lv_o;
  logic [9:0] px_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int line_a [0:63];
  int out_b  [0:63];
  int out_n  = 0;
  int first_cyc = -1;
  bit done  = 0;

  bpr_hline dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .thresh_i(thr),
    .line_valid_i(lv_i), .pix_i(px_i), .line_valid_o(lv_o), .pix_o(px_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && lv_o) begin
      if (out_n == 0) first_cyc = cyc;
      if (out_n < 64) out_b[out_n] = int'(px_o);
      out_n = out_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_pix(input int i, input int n, input bit e, input int t,
                                    output string req);
    int c, l, r;
    c = line_a[i];
    if (!e) begin req = "R6"; return c; end
    if (i < 2 || i + 2 >= n) begin req = "R7"; return c; end
    l = line_a[i-2];
    r = line_a[i+2];
    if (c > l + t && c > r + t) begin req = "R3 R5 R9"; return (l + r) / 2; end
    if (c + t < l && c + t < r) begin req = "R4 R5 R9"; return (l + r) / 2; end
    req = "R3 R4 R9";
    return c;
  endfunction

  task automatic run_line(input int n, input bit e, input int t);
    int start;
    string req;
    int ex;
    out_n = 0;
    first_cyc = -1;
    start = 0;
    @(negedge clk);
    en  = e;
    thr = 7'(t);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 0) start = cyc;
      lv_i = 1'b1;
      px_i = 10'(line_a[i]);
    end
    @(negedge clk);
    lv_i = 1'b0;
    repeat (4) @(negedge clk);
    check(out_n == n, "R8", out_n, n);
    if (n >= 3) check(first_cyc - start == 3, "R2", first_cyc - start, 3);
    for (int i = 0; i < n && i < out_n; i++) begin
      ex = expect_pix(i, n, e, t, req);
      check(out_b[i] == ex, req, out_b[i], ex);
    end
  endtask

  function automatic int clip(input int v);
    return (v < 0) ? 0 : ((v > 1023) ? 1023 : v);
  endfunction

  initial begin
    int thr_set [4] = '{0, 1, 20, 127};
    int lvl_l   [3] = '{0, 300, 1023};
    int lvl_r   [3] = '{0, 310, 1023};
    int cand    [7];
    int lo, hi, t;
    int lfsr;

    // R1: reset state, during reset and on the first cycle after release
    repeat (3) @(negedge clk);
    check(lv_o == 1'b0 && px_o == 10'd0, "R1", int'(px_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(lv_o == 1'b0 && px_o == 10'd0, "R1", int'(lv_o), 0);
    repeat (2) @(negedge clk);

    // R3 R4 R5 R9: threshold boundary sweep on five-pixel lines
    for (int ti = 0; ti < 4; ti++) begin
      t = thr_set[ti];
      for (int li = 0; li < 3; li++) begin
        for (int ri = 0; ri < 3; ri++) begin
          lo = (lvl_l[li] < lvl_r[ri]) ? lvl_l[li] : lvl_r[ri];
          hi = (lvl_l[li] < lvl_r[ri]) ? lvl_r[ri] : lvl_l[li];
          cand = '{hi + t, hi + t + 1, lo - t, lo - t - 1, (lo + hi) / 2, 0, 1023};
          for (int ci = 0; ci < 7; ci++) begin
            if (cand[ci] < 0 || cand[ci] > 1023) continue;
            line_a[0] = lvl_l[li];
            line_a[2] = cand[ci];
            line_a[4] = lvl_r[ri];
            line_a[1] = 1023 - cand[ci];   // adjacent columns: must not matter
            line_a[3] = 1023 - cand[ci];
            run_line(5, 1'b1, t);
            if (ti == 0) run_line(5, 1'b0, t);   // R6 bypass
          end
        end
      end
    end

    // R7 R8: short lines with spiky content stay untouched and drain fully
    for (int n = 1; n <= 4; n++) begin
      for (int i = 0; i < n; i++) line_a[i] = (i % 2 == 0) ? 1023 : 0;
      run_line(n, 1'b1, 0);
    end

    // R2 R5 R7 R8: long pseudo-random line with injected hot and dead pixels
    lfsr = 16'hACE1;
    for (int i = 0; i < 48; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      line_a[i] = 400 + (lfsr % 64);
    end
    line_a[0] = 1000; line_a[1] = 5; line_a[10] = 1023; line_a[17] = 0;
    line_a[30] = 900; line_a[46] = 1010; line_a[47] = 2;
    run_line(48, 1'b1, 20);
    run_line(48, 1'b0, 20);
    run_line(48, 1'b1, 127);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule